// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

This block holds a 16-bit up-counter that runs all the time from the bus clock through two divider stages. The first stage divides by 1, 4, 8 or 16, as chosen by a two-bit select input. The second stage divides by a fixed parameter, which is 4 by default. A CPU reads the count one byte at a time through a small read port. The port offers two address pairs, primary and alternate, and both return the same count.

When a CPU reads a high byte, the low byte of that moment is held in a buffer that belongs to the pair. The matching low-byte read returns that buffer, so a 16-bit value read in two steps is always consistent. When the count wraps, an overflow flag sets. It can drive an interrupt line. Software clears it by reading the status register and then the primary low byte. The alternate pair lets software read the count without any risk of clearing a pending overflow.

Top module: `frt_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0xFFFC, the divider chain goes to phase zero, the overflow flag clears and `irq` goes low.
- R2: With `POST_DIV` = 4, the select values 0, 1, 2 and 3 advance the count once every 4, 16, 32 and 64 bus clocks. After reset release, the first advance happens on the N-th rising edge, where N is the ratio.
- R3: While `inhibit` is high, the count and the divider phase both hold. After release, counting resumes from the held phase.
- R4: When `rd_en` is high, `rd_data` (combinational) returns a value set by `rd_addr`. Address 0 gives status, with the overflow flag in bit 7 and zeros elsewhere. Address 2 gives the primary high byte and 3 the primary low byte. Address 4 gives the alternate high byte and 5 the alternate low byte. Any other address gives 0x00. No read changes the count.
- R5: A low-byte read on a pair with no pending high-byte read returns the live low byte.
- R6: A high-byte read returns the live high byte. If no capture is pending on that pair, it also captures the live low byte into the pair's buffer. Further high-byte reads leave the buffer unchanged. The next low-byte read on that pair returns the buffer and ends the capture. Each pair has its own buffer.
- R7: The alternate pair returns the same count values as the primary pair and follows the same capture rule.
- R8: The overflow flag sets on the edge where the count wraps from 0xFFFF to 0x0000.
- R9: `irq` is high exactly when both the overflow flag and `ovf_ie` are high.
- R10: The flag clears only on a primary low-byte read that follows a status read made while the flag was set. The next primary low-byte read uses up that arming. Alternate-pair reads never clear the flag and never use up the arming.
- R11: Overflows repeat every 65536 × (first-stage divide × `POST_DIV`) bus clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| inhibit | input | 1 | Freezes the count and the divider chain |
| clk_sel | input | 2 | First-stage divide select |
| ovf_ie | input | 1 | Overflow interrupt enable |
| rd_en | input | 1 | Read strobe, one access per cycle |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, valid in the same cycle as `rd_en` |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds two copies. The first uses the default second-stage divide of 4, which brings every select rate, the inhibit freeze, the capture buffers and the overflow clearing rules into view within a few dozen cycles of reset. The second is built with a second-stage divide of 1, so the counter runs at the bus rate. That makes a full 65536-tick period short enough to check that the second overflow lands on exactly the predicted edge.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;

    localparam int CNT_W        = 16;
    localparam int BYTE_W       = 8;
    localparam int SEL_W        = 2;
    localparam int PRE_W        = 4;
    localparam int ADDR_W       = 3;
    localparam int NUM_PAIRS    = 2;
    localparam int STAT_OVF_BIT = 7;

    localparam logic [CNT_W-1:0] COUNT_PRESET = 16'hFFFC;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 3'd0,
        RA_PRI_HI = 3'd2,
        RA_PRI_LO = 3'd3,
        RA_ALT_HI = 3'd4,
        RA_ALT_LO = 3'd5
    } rd_addr_e;

    // One strobe per register access; index 0 = primary pair, 1 = alternate.
    typedef struct packed {
        logic                 status;
        logic [NUM_PAIRS-1:0] hi;
        logic [NUM_PAIRS-1:0] lo;
    } rd_strobe_t;

    // First-stage mask: a tick fires when the masked phase bits are all ones.
    function automatic logic [PRE_W-1:0] pre_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] m;
        case (sel)
            2'd0:    m = 4'h0;
            2'd1:    m = 4'h3;
            2'd2:    m = 4'h7;
            default: m = 4'hF;
        endcase
        return m;
    endfunction

    function automatic rd_strobe_t decode_read(input logic en,
                                               input logic [ADDR_W-1:0] a);
        rd_strobe_t s;
        s = '0;
        if (en) begin
            case (a)
                RA_STATUS: s.status = 1'b1;
                RA_PRI_HI: s.hi[0]  = 1'b1;
                RA_PRI_LO: s.lo[0]  = 1'b1;
                RA_ALT_HI: s.hi[1]  = 1'b1;
                RA_ALT_LO: s.lo[1]  = 1'b1;
                default:   s        = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/frt_prescaler.sv
`timescale 1ns/1ps
module frt_prescaler
    import frt_pkg::*;
#(
    parameter int POST_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int QW = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             pre_tick;

    assign mask     = pre_mask(sel);
    assign pre_tick = ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst)        pre_q <= '0;
        else if (!hold) pre_q <= pre_q + 1'b1;
    end

    generate
        if (POST_DIV == 1) begin : g_no_post
            assign tick = !hold && pre_tick;
        end else begin : g_post
            logic [QW-1:0] post_q;
            logic          post_last;
            assign post_last = (post_q == QW'(POST_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst)
                    post_q <= '0;
                else if (!hold && pre_tick)
                    post_q <= post_last ? '0 : post_q + 1'b1;
            end
            assign tick = !hold && pre_tick && post_last;
        end
    endgenerate

endmodule

// File: rtl/frt_counter.sv
`timescale 1ns/1ps
module frt_counter
    import frt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = tick && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)       count <= COUNT_PRESET;
        else if (tick) count <= count + 1'b1;
    end

    // R2: each divider tick moves the count up by exactly one
    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/frt_status.sv
`timescale 1ns/1ps
module frt_status (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic status_rd,
    input  logic pri_lo_rd,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (status_rd && flag) armed <= 1'b1;
            else if (pri_lo_rd)    armed <= 1'b0;

            if (wrap)                       flag <= 1'b1;
            else if (pri_lo_rd && armed)    flag <= 1'b0;
        end
    end

    // R10: a primary low read with no arming leaves a set flag in place
    a_r10_unarmed_keeps: assert property (@(posedge clk) disable iff (rst)
        (flag && !armed && !status_rd) |=> flag);

endmodule

// File: rtl/frt_read_port.sv
`timescale 1ns/1ps
module frt_read_port
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rd_strobe_t        stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    output logic [BYTE_W-1:0] rd_data
);
    logic [NUM_PAIRS-1:0][BYTE_W-1:0] pair_lo;
    logic [BYTE_W-1:0]                live_hi;
    logic [BYTE_W-1:0]                status_byte;

    assign live_hi = count[CNT_W-1 -: BYTE_W];

    always_comb begin
        status_byte               = '0;
        status_byte[STAT_OVF_BIT] = flag;
    end

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            logic              latched;
            logic [BYTE_W-1:0] held;

            always_ff @(posedge clk) begin
                if (rst) begin
                    latched <= 1'b0;
                    held    <= '0;
                end else if (stb.hi[p] && !latched) begin
                    latched <= 1'b1;
                    held    <= count[BYTE_W-1:0];
                end else if (stb.lo[p]) begin
                    latched <= 1'b0;
                end
            end

            assign pair_lo[p] = latched ? held : count[BYTE_W-1:0];

            // R6: a repeated high read does not disturb the captured byte
            a_r6_buffer_hold: assert property (@(posedge clk) disable iff (rst)
                (stb.hi[p] && latched) |=> ($stable(held) && latched));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                RA_STATUS: rd_data = status_byte;
                RA_PRI_HI: rd_data = live_hi;
                RA_PRI_LO: rd_data = pair_lo[0];
                RA_ALT_HI: rd_data = live_hi;
                RA_ALT_LO: rd_data = pair_lo[1];
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/frt_timer.sv
`timescale 1ns/1ps
module frt_timer
    import frt_pkg::*;
#(
    parameter int POST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inhibit,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              ovf_ie,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_flag,
    output logic              irq
);
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;
    rd_strobe_t       stb;

    assign stb = decode_read(rd_en, rd_addr);

    frt_prescaler #(.POST_DIV(POST_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .hold (inhibit),
        .sel  (clk_sel),
        .tick (tick)
    );

    frt_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (count),
        .wrap  (wrap)
    );

    frt_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .status_rd (stb.status),
        .pri_lo_rd (stb.lo[0]),
        .flag      (ovf_flag)
    );

    frt_read_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .rd_addr (rd_addr),
        .rd_en   (rd_en),
        .count   (count),
        .flag    (ovf_flag),
        .rd_data (rd_data)
    );

    assign irq = ovf_flag && ovf_ie;

    // R3: inhibit freezes the count
    a_r3_inhibit_hold: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> $stable(count));

    // R8: a wrap always leaves the flag set
    a_r8_wrap_sets: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag);

    // R10: alternate-pair reads never clear the flag
    a_r10_alt_keeps: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && (stb.hi[1] || stb.lo[1])) |=> ovf_flag);

endmodule

// File: tb/sim_frt_timer.sv
`timescale 1ns/1ps
module sim_frt_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inhibit = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic       ovf_ie = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       ovf_flag;
    logic       irq;
    logic       rd_en1 = 1'b0;
    logic [2:0] rd_addr1 = 3'd0;
    logic [7:0] rd_data1;
    logic       ovf_flag1;
    logic       irq1;

    int checks = 0;
    int failures = 0;
    int ecount = 0;

    localparam logic [2:0] A_STAT = 3'd0, A_PHI = 3'd2, A_PLO = 3'd3,
                           A_AHI = 3'd4, A_ALO = 3'd5;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    frt_timer #(.POST_DIV(4)) u0 (
        .clk(clk), .rst(rst), .inhibit(inhibit), .clk_sel(clk_sel),
        .ovf_ie(ovf_ie), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_flag(ovf_flag), .irq(irq)
    );

    frt_timer #(.POST_DIV(1)) u1 (
        .clk(clk), .rst(rst), .inhibit(inhibit), .clk_sel(clk_sel),
        .ovf_ie(ovf_ie), .rd_en(rd_en1), .rd_addr(rd_addr1),
        .rd_data(rd_data1), .ovf_flag(ovf_flag1), .irq(irq1)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_lo(input int n);
        logic [15:0] v;
        v = 16'hFFFC + 16'(ecount / n);
        return v[7:0];
    endfunction

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst = 1'b1; clk_sel = sel; inhibit = 1'b0; rd_en = 0; rd_en1 = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input bit second, input logic [2:0] a, output logic [7:0] d);
        if (!second) begin rd_en = 1'b1; rd_addr = a; end
        else         begin rd_en1 = 1'b1; rd_addr1 = a; end
        #1;
        d = second ? rd_data1 : rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_en1 = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        ovf_ie = 1'b1;
        do_reset(2'd3);
        chk("R1 flag after reset", 16'(ovf_flag), 16'h0);
        chk("R9 irq after reset", 16'(irq), 16'h0);
        rd(0, A_PHI, d);  chk("R1 high byte preset", 16'(d), 16'h00FF);
        rd(0, A_PLO, d);  chk("R1 low byte preset", 16'(d), 16'h00FC);
        rd(0, A_STAT, d); chk("R4 status clear", 16'(d), 16'h0000);
        rd(0, 3'd1, d);   chk("R4 unused address 1", 16'(d), 16'h0000);
        rd(0, 3'd7, d);   chk("R4 unused address 7", 16'(d), 16'h0000);
    endtask

    task automatic t_rate;
        logic [7:0] d;
        logic [7:0] e;
        for (int s = 0; s < 4; s++) begin
            int n;
            n = (s == 0) ? 4 : (s == 1) ? 16 : (s == 2) ? 32 : 64;
            do_reset(2'(s));
            wait_edges(n - 1);
            rd(0, A_PLO, d); chk("R2 before first step", 16'(d), 16'h00FC);
            rd(0, A_PLO, d); chk("R2 first step on edge N", 16'(d), 16'h00FD);
            wait_edges(3 * n);
            e = exp_lo(n);
            rd(0, A_PLO, d); chk("R2 rate after wrap", 16'(d), 16'(e));
        end
    endtask

    task automatic t_inhibit;
        logic [7:0] d;
        do_reset(2'd0);
        wait_edges(6);
        inhibit = 1'b1;
        rd(0, A_PLO, d); chk("R3 value at inhibit", 16'(d), 16'h00FD);
        wait_edges(40);
        rd(0, A_PLO, d); chk("R3 held during inhibit", 16'(d), 16'h00FD);
        inhibit = 1'b0;
        wait_edges(1);
        rd(0, A_PLO, d); chk("R3 phase kept, no early step", 16'(d), 16'h00FD);
        rd(0, A_PLO, d); chk("R3 resumes from held phase", 16'(d), 16'h00FE);
    endtask

    task automatic t_coherent;
        logic [7:0] d;
        do_reset(2'd0);
        rd(0, A_PLO, d); chk("R5 live low", 16'(d), 16'h00FC);
        rd(0, A_PHI, d); chk("R6 high read", 16'(d), 16'h00FF);
        wait_edges(14);
        rd(0, A_PHI, d); chk("R6 repeat high read live", 16'(d), 16'h0000);
        rd(0, A_PLO, d); chk("R6 low returns first capture", 16'(d), 16'h00FC);
        rd(0, A_PLO, d); chk("R5 sequence ended, live low", 16'(d), 16'h0000);
        wait_edges(1);
        rd(0, A_AHI, d); chk("R7 alternate high", 16'(d), 16'h0000);
        wait_edges(7);
        rd(0, A_PLO, d); chk("R7 primary independent of alternate", 16'(d), 16'h0003);
        rd(0, A_ALO, d); chk("R7 alternate buffered low", 16'(d), 16'h0001);
        rd(0, A_ALO, d); chk("R7 alternate live low", 16'(d), 16'h0003);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        ovf_ie = 1'b1;
        do_reset(2'd0);
        wait_edges(15);
        chk("R8 no flag before wrap", 16'(ovf_flag), 16'h0);
        wait_edges(1);
        chk("R8 flag on wrap edge", 16'(ovf_flag), 16'h1);
        chk("R9 irq enabled", 16'(irq), 16'h1);
        ovf_ie = 1'b0; #1;
        chk("R9 irq masked", 16'(irq), 16'h0);
        ovf_ie = 1'b1;
        rd(0, A_STAT, d); chk("R4 status flag bit 7", 16'(d), 16'h0080);
        rd(0, A_ALO, d);
        chk("R10 alternate low keeps flag", 16'(ovf_flag), 16'h1);
        rd(0, A_AHI, d);
        rd(0, A_ALO, d);
        chk("R10 alternate pair keeps flag", 16'(ovf_flag), 16'h1);
        rd(0, A_PLO, d);
        chk("R10 armed primary low clears", 16'(ovf_flag), 16'h0);
        rd(0, A_STAT, d); chk("R10 status after clear", 16'(d), 16'h0000);

        do_reset(2'd0);
        rd(0, A_STAT, d);
        wait_edges(15);
        chk("R8 flag set again", 16'(ovf_flag), 16'h1);
        rd(0, A_PLO, d);
        chk("R10 status read with flag low does not arm", 16'(ovf_flag), 16'h1);
        rd(0, A_STAT, d);
        rd(0, A_PLO, d);
        chk("R10 proper sequence clears", 16'(ovf_flag), 16'h0);
    endtask

    task automatic t_period;
        logic [7:0] d;
        do_reset(2'd0);
        wait_edges(4);
        chk("R11 first wrap at ratio 1", 16'(ovf_flag1), 16'h1);
        rd(1, A_STAT, d);
        rd(1, A_PLO, d);
        chk("R10 clear on second copy", 16'(ovf_flag1), 16'h0);
        wait_edges(65539 - ecount);
        chk("R11 no wrap one edge early", 16'(ovf_flag1), 16'h0);
        wait_edges(1);
        chk("R11 second wrap after 65536 cycles", 16'(ovf_flag1), 16'h1);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_rate();
        t_inhibit();
        t_coherent();
        t_overflow();
        t_period();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule